// File: doc/BRIEF.md
# Single-Word System Bus Bridge

This block lets a local processor carry out one word-sized read or write on a separate system bus. The processor programs a target address, write data where the transfer is a write, and optionally a time limit. It then writes the control register with the launch bit and exactly one direction bit. The bridge drives a request/acknowledge master port, holds the request until the far side answers or the limit runs out, and reports the outcome in a two-bit status field that the processor polls.

A read places the returned word in the data register. A write sends the data register together with a per-byte lane-enable mask, and the target updates only the enabled bytes. An error response from the target, an expired time limit, or a command asking for both directions at once leaves the status at the error code. The error code stays until the next accepted command. While a transfer is in flight, the address, data and control registers are frozen, so the request on the bus cannot change under the target.

Top module: `word_bridge`

## Requirements
- R1: After reset, the status field is idle (0), the control, address and data registers read 0, the timeout register reads 0x00000FFF, and `bus_req` is low.
- R2: Word-aligned processor accesses select the registers by `cpu_addr[3:2]`: 0 is control, 1 is address, 2 is data and 3 is timeout. A write with `cpu_addr[1:0]` not zero changes nothing. The control register reads back the read bit at bit 0, the write bit at bit 1, the byte mask at bits 7:4 and the status at bits 13:12, with every other bit 0. The launch bit 31 therefore always reads 0.
- R3: A control write with bit 31 set and exactly one of bits 0 and 1 set starts a transfer. On the next cycle the status reads busy (1) and `bus_req` is high, carrying the address register, the data register, the mask and `bus_we` equal to bit 1. A control write without bit 31 starts nothing.
- R4: When `bus_ack` is high without `bus_err` on a cycle where `bus_req` is high, the transfer ends. On the next cycle the status is idle, `bus_req` is low, and for a read the data register holds `bus_rdata`.
- R5: During a write, `bus_be` equals the mask. Mask bit 0 enables data bits 7:0, bit 1 enables 15:8, bit 2 enables 23:16 and bit 3 enables 31:24. A zero mask still completes the handshake and ends idle.
- R6: When `bus_err` is high on a cycle where `bus_req` is high, the transfer ends with status error (2) and the data register unchanged.
- R7: With no response, `bus_req` stays high for exactly max(T,1) cycles, where T is the timeout register value. The status then becomes error (2).
- R8: A control write with bit 31 and both direction bits set makes the status error (2) on the next cycle and raises no `bus_req`.
- R9: While the status is busy, processor writes to the control, address and data registers are ignored.
- R10: The status field never reads 3.
- R11: A command accepted while the status shows error starts a normal transfer, and the status turns busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Processor register write strobe |
| cpu_addr | input | 4 | Processor byte offset into the register bank |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr`, combinational |
| bus_req | output | 1 | Transfer request, held until the transfer ends |
| bus_we | output | 1 | 1 for a write transfer, 0 for a read |
| bus_addr | output | 32 | Target address |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte-lane enables |
| bus_ack | input | 1 | Target completed the transfer |
| bus_err | input | 1 | Target rejected the transfer (invalid address) |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
A control write takes effect at the clock edge that samples it, so the status and `bus_req` are checked at the falling edge just after that write. A target response, or the final cycle of the time limit, is consumed at the next rising edge, and the status and data register show the result one cycle later. The bench model drives its answers on falling edges and reads every result at a falling edge, never at the rising edge that produces it. The length of a timeout is measured by counting the falling edges on which `bus_req` is high, and that count is compared with max(T,1).

// File: rtl/wbr_pkg.sv
package wbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ERR  = 2'd2
  } xfer_st_t;

  // register selector, taken from cpu_addr[3:2]
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_ADR = 2'd1;
  localparam logic [1:0] SEL_DAT = 2'd2;
  localparam logic [1:0] SEL_TMO = 2'd3;

  // control register field positions
  localparam int CTL_RD    = 0;
  localparam int CTL_WR    = 1;
  localparam int CTL_BE_LO = 4;
  localparam int CTL_ST_LO = 12;
  localparam int CTL_GO    = 31;

  // accepted command: launch bit plus exactly one direction
  function automatic logic cmd_valid(input logic go, input logic rd, input logic wr);
    return go & (rd ^ wr);
  endfunction

  // rejected command: launch bit plus both directions
  function automatic logic cmd_conflict(input logic go, input logic rd, input logic wr);
    return go & rd & wr;
  endfunction

endpackage

// File: rtl/wbr_regbank.sv
module wbr_regbank
  import wbr_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter logic [31:0] TMO_RST = 32'h0000_0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [3:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          busy,
  input  xfer_st_t      st,
  input  logic          load_rdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          rd_q,
  output logic          wr_q,
  output logic [DW/8-1:0] be_q,
  output logic [DW-1:0] tmo_q,
  output logic          cmd_go,
  output logic          cmd_bad
);
  localparam int BE_W = DW / 8;

  logic [1:0] sel;
  logic       aligned;
  logic       wr_any;
  logic       wr_frz;

  assign sel     = cpu_addr[3:2];
  assign aligned = (cpu_addr[1:0] == 2'b00);
  assign wr_any  = cpu_we & aligned;
  assign wr_frz  = wr_any & ~busy;

  assign cmd_go  = wr_frz & (sel == SEL_CTL) &
                   cmd_valid(cpu_wdata[CTL_GO], cpu_wdata[CTL_RD], cpu_wdata[CTL_WR]);
  assign cmd_bad = wr_frz & (sel == SEL_CTL) &
                   cmd_conflict(cpu_wdata[CTL_GO], cpu_wdata[CTL_RD], cpu_wdata[CTL_WR]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      be_q   <= '0;
      tmo_q  <= TMO_RST[DW-1:0];
    end else begin
      if (wr_frz && sel == SEL_CTL) begin
        rd_q <= cpu_wdata[CTL_RD];
        wr_q <= cpu_wdata[CTL_WR];
        be_q <= cpu_wdata[CTL_BE_LO +: BE_W];
      end
      if (wr_frz && sel == SEL_ADR) addr_q <= cpu_wdata[AW-1:0];
      if (load_rdata)                          data_q <= bus_rdata;
      else if (wr_frz && sel == SEL_DAT)       data_q <= cpu_wdata;
      if (wr_any && sel == SEL_TMO)            tmo_q  <= cpu_wdata;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    unique case (sel)
      SEL_CTL: begin
        cpu_rdata[CTL_RD]              = rd_q;
        cpu_rdata[CTL_WR]              = wr_q;
        cpu_rdata[CTL_BE_LO +: BE_W]   = be_q;
        cpu_rdata[CTL_ST_LO +: 2]      = st;
      end
      SEL_ADR: cpu_rdata[AW-1:0] = addr_q;
      SEL_DAT: cpu_rdata         = data_q;
      default: cpu_rdata         = tmo_q;
    endcase
  end

  // R9: frozen registers during a transfer
  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cpu_we && sel == SEL_ADR |=> $stable(addr_q));
  assert_ctl_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cpu_we && sel == SEL_CTL |=> $stable(be_q) && $stable(rd_q) && $stable(wr_q));
  assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !load_rdata && cpu_we && sel == SEL_DAT |=> $stable(data_q));
  // R4: read data captured from the bus
  assert_rdata_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_rdata |=> data_q == $past(bus_rdata));

endmodule

// File: rtl/wbr_xfer.sv
module wbr_xfer
  import wbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic          cmd_bad,
  input  logic          rd_q,
  input  logic [DW-1:0] tmo_q,
  input  logic          bus_ack,
  input  logic          bus_err,
  output xfer_st_t      st,
  output logic          busy,
  output logic          bus_req,
  output logic          load_rdata
);
  logic [DW-1:0] wait_cnt;
  logic          xfer_ok;
  logic          xfer_bad;
  logic          xfer_tmo;

  // limit reached when this waiting cycle is the T-th one (0 acts as 1)
  function automatic logic limit_hit(input logic [DW-1:0] cnt, input logic [DW-1:0] lim);
    logic [DW:0] next;
    next = {1'b0, cnt} + 1'b1;
    return next >= {1'b0, lim};
  endfunction

  assign busy       = (st == ST_BUSY);
  assign xfer_bad   = bus_req & bus_err;
  assign xfer_ok    = bus_req & bus_ack & ~bus_err;
  assign xfer_tmo   = bus_req & ~bus_ack & ~bus_err & limit_hit(wait_cnt, tmo_q);
  assign load_rdata = xfer_ok & rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bus_req  <= 1'b0;
      wait_cnt <= '0;
    end else if (!busy) begin
      if (cmd_go) begin
        st       <= ST_BUSY;
        bus_req  <= 1'b1;
        wait_cnt <= '0;
      end else if (cmd_bad) begin
        st <= ST_ERR;
      end
    end else if (xfer_bad || xfer_tmo) begin
      st      <= ST_ERR;
      bus_req <= 1'b0;
    end else if (xfer_ok) begin
      st      <= ST_IDLE;
      bus_req <= 1'b0;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> st == ST_BUSY && bus_req);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |=> st == ST_IDLE && !bus_req);
  assert_err_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_bad |=> st == ST_ERR && !bus_req);
  assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_tmo |=> st == ST_ERR && !bus_req);
  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err && !xfer_tmo |=> bus_req);
  assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> st == ST_ERR && !bus_req);
  assert_no_code3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'd3);
  assert_recover_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_ERR && cmd_go |=> st == ST_BUSY);

endmodule

// File: rtl/word_bridge.sv
module word_bridge
  import wbr_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter logic [31:0] TMO_RST = 32'h0000_0FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  input  logic [3:0]      cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [DW/8-1:0] bus_be,
  input  logic            bus_ack,
  input  logic            bus_err,
  input  logic [DW-1:0]   bus_rdata
);
  localparam int BE_W = DW / 8;

  xfer_st_t        st;
  logic            busy;
  logic            load_rdata;
  logic            cmd_go;
  logic            cmd_bad;
  logic            rd_q;
  logic            wr_q;
  logic [BE_W-1:0] be_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [DW-1:0]   tmo_q;

  wbr_regbank #(.AW(AW), .DW(DW), .TMO_RST(TMO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .st(st), .load_rdata(load_rdata), .bus_rdata(bus_rdata),
    .addr_q(addr_q), .data_q(data_q), .rd_q(rd_q), .wr_q(wr_q), .be_q(be_q),
    .tmo_q(tmo_q), .cmd_go(cmd_go), .cmd_bad(cmd_bad)
  );

  wbr_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_bad(cmd_bad), .rd_q(rd_q), .tmo_q(tmo_q),
    .bus_ack(bus_ack), .bus_err(bus_err),
    .st(st), .busy(busy), .bus_req(bus_req), .load_rdata(load_rdata)
  );

  assign bus_we    = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;
  assign bus_be    = be_q;

  // R5: request fields hold steady while waiting for the target
  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err |=> $stable(bus_addr) && $stable(bus_be) && $stable(bus_we));

endmodule

// File: tb/sim_word_bridge.sv
module sim_word_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_addr = 4'h0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit code3_seen = 1'b0;

  // target model
  int          tgt_mode = 0;   // 0 ack, 1 error, 2 silent
  int          tgt_delay = 0;
  int          wcnt = 0;
  logic [31:0] tgt_word = '0;
  logic [3:0]  seen_be = '0;
  logic        seen_we = 1'b0;
  logic [31:0] seen_addr = '0;

  assign bus_rdata = tgt_word;

  always #5 clk = ~clk;

  word_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; bus_err = 1'b0; wcnt = 0;
    end else if (bus_ack || bus_err) begin
      bus_ack = 1'b0; bus_err = 1'b0; wcnt = 0;
    end else if (bus_req) begin
      seen_be = bus_be; seen_we = bus_we; seen_addr = bus_addr;
      if (tgt_mode != 2 && wcnt >= tgt_delay) begin
        if (tgt_mode == 1) bus_err = 1'b1;
        else begin
          bus_ack = 1'b1;
          if (bus_we)
            for (int i = 0; i < 4; i++)
              if (bus_be[i]) tgt_word[8*i +: 8] = bus_wdata[8*i +: 8];
        end
      end else wcnt++;
    end else wcnt = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles exp < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", rq, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = v; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [3:0] a, output logic [31:0] v);
    cpu_addr = a;
    #1;
    v = cpu_rdata;
    if (a == 4'h0 && v[13:12] == 2'd3) code3_seen = 1'b1;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      cpu_read(4'h0, v);
      if (v[13:12] != 2'd1) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    cpu_read(4'h0, v); chk("R1 ctrl", v, 32'h0);
    cpu_read(4'h4, v); chk("R1 addr", v, 32'h0);
    cpu_read(4'h8, v); chk("R1 data", v, 32'h0);
    cpu_read(4'hC, v); chk("R1 timeout", v, 32'h0000_0FFF);
    chk("R1 bus_req", {31'b0, bus_req}, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    cpu_write(4'h4, 32'h1000_0040);
    cpu_write(4'h8, 32'h5A5A_0F0F);
    cpu_write(4'hC, 32'h0000_0020);
    cpu_write(4'h5, 32'hDEAD_BEEF);   // misaligned: ignored
    cpu_read(4'h4, v); chk("R2 addr readback", v, 32'h1000_0040);
    cpu_read(4'h8, v); chk("R2 data readback", v, 32'h5A5A_0F0F);
    cpu_read(4'hC, v); chk("R2 timeout readback", v, 32'h0000_0020);
    cpu_write(4'h0, 32'h0000_00F3);   // no launch bit
    @(negedge clk);
    chk("R3 no launch no req", {31'b0, bus_req}, 32'h0);
    cpu_read(4'h0, v); chk("R2 ctrl fields", v, 32'h0000_00F3);
  endtask

  task automatic t_read();
    logic [31:0] v;
    tgt_mode = 0; tgt_delay = 2; tgt_word = 32'hCAFE_0123;
    cpu_write(4'h0, 32'h8000_00F1);
    cpu_read(4'h0, v); chk("R3 busy after start", v, 32'h0000_10F1);
    chk("R3 bus_req high", {31'b0, bus_req}, 32'h1);
    chk("R3 bus_addr", bus_addr, 32'h1000_0040);
    chk("R3 bus_we read", {31'b0, bus_we}, 32'h0);
    wait_idle();
    @(negedge clk);
    chk("R4 req dropped", {31'b0, bus_req}, 32'h0);
    cpu_read(4'h8, v); chk("R4 read data", v, 32'hCAFE_0123);
    cpu_read(4'h0, v); chk("R2 launch self-clears", v, 32'h0000_00F1);
  endtask

  task automatic t_write_mask();
    logic [31:0] v;
    tgt_mode = 0; tgt_delay = 1; tgt_word = 32'h1122_3344;
    cpu_write(4'h8, 32'hAABB_CCDD);
    cpu_write(4'h0, 32'h8000_0052);
    chk("R5 bus_be", {28'b0, bus_be}, 32'h5);
    chk("R3 bus_we write", {31'b0, bus_we}, 32'h1);
    chk("R3 bus_wdata", bus_wdata, 32'hAABB_CCDD);
    wait_idle();
    chk("R5 lanes merged", tgt_word, 32'h11BB_33DD);
    cpu_read(4'h0, v); chk("R5 idle after write", v, 32'h0000_0052);
  endtask

  task automatic t_mask_zero();
    logic [31:0] v;
    tgt_mode = 0; tgt_delay = 0; tgt_word = 32'h0102_0304;
    cpu_write(4'h0, 32'h8000_0002);
    wait_idle();
    chk("R5 zero mask keeps word", tgt_word, 32'h0102_0304);
    cpu_read(4'h0, v); chk("R5 zero mask idle", v, 32'h0000_0002);
  endtask

  task automatic t_err_resp();
    logic [31:0] v;
    tgt_mode = 1; tgt_delay = 1; tgt_word = 32'h7777_7777;
    cpu_write(4'h0, 32'h8000_00F1);
    wait_idle();
    cpu_read(4'h0, v); chk("R6 error status", v, 32'h0000_20F1);
    cpu_read(4'h8, v); chk("R6 data unchanged", v, 32'hAABB_CCDD);
    chk("R6 req low", {31'b0, bus_req}, 32'h0);
  endtask

  task automatic t_timeout(input logic [31:0] lim, input int exp_cyc);
    logic [31:0] v;
    int n;
    tgt_mode = 2;
    cpu_write(4'hC, lim);
    cpu_write(4'h0, 32'h8000_00F1);
    n = 0;
    while (bus_req && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R7 request length", n, exp_cyc);
    cpu_read(4'h0, v); chk("R7 timeout error", v, 32'h0000_20F1);
  endtask

  task automatic t_recover();
    logic [31:0] v;
    tgt_mode = 0; tgt_delay = 3;
    cpu_write(4'hC, 32'h0000_0FFF);
    cpu_write(4'h0, 32'h8000_00F1);
    cpu_read(4'h0, v); chk("R11 busy from error", v, 32'h0000_10F1);
    wait_idle();
    cpu_read(4'h0, v); chk("R11 idle after recovery", v, 32'h0000_00F1);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    int hits;
    cpu_write(4'h0, 32'h8000_00F3);
    hits = 0;
    for (int i = 0; i < 4; i++) begin
      if (bus_req) hits++;
      @(negedge clk);
    end
    chk("R8 no request", hits, 0);
    cpu_read(4'h0, v); chk("R8 error status", v, 32'h0000_20F3);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    tgt_mode = 0; tgt_delay = 8; tgt_word = 32'h600D_F00D;
    cpu_write(4'h4, 32'h0000_0200);
    cpu_write(4'h0, 32'h8000_00F1);
    cpu_write(4'h4, 32'h0000_0300);
    cpu_write(4'h8, 32'h0000_1234);
    cpu_write(4'h0, 32'h8000_0002);
    chk("R9 bus_addr held", bus_addr, 32'h0000_0200);
    chk("R9 bus_we held", {31'b0, bus_we}, 32'h0);
    wait_idle();
    cpu_read(4'h4, v); chk("R9 addr ignored", v, 32'h0000_0200);
    cpu_read(4'h8, v); chk("R9 data ignored", v, 32'h600D_F00D);
    cpu_read(4'h0, v); chk("R9 ctrl ignored", v, 32'h0000_00F1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_read();
    t_write_mask();
    t_mask_zero();
    t_err_resp();
    t_timeout(32'd5, 5);
    t_timeout(32'd0, 1);
    t_recover();
    t_illegal();
    t_busy_ignore();
    chk("R10 status code 3 never seen", {31'b0, code3_seen}, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule